// File: doc/BRIEF.md
# Multiplexed Bus Transaction Sequencer

This block sits between a small embedded processor core and a multiplexed address/data bus. The core hands it one request at a time: a single-word read, a four-word instruction-cache refill, a four-word data-cache refill, or a single-word write. The block puts the word address on the shared bus for one cycle and raises the read or write strobe. It then waits on the memory side. On a read, every cycle where memory signals that data is valid latches one bus word into a small read buffer. Memory separately acknowledges that the transaction has been processed. When both conditions are met, the block pulses a completion signal to the core, and the buffered words are presented alongside it.

One bus output has a meaning that depends on direction. During a read it marks a four-word refill burst. Instruction refills are always burst. Data refills are burst only when that option was sampled in the final cycle of reset; without it they run as single-word reads. During a write the same output marks a write that directly follows a previous write in the same 256-word page, so page-mode memory can retire it quickly.

A bus error input ends the current transaction early, and a read that ends this way raises an exception pulse instead of a completion pulse. An external master can ask for the bus. The block grants it only between transactions, and while the bus is granted it drops its output enable.

Top module: `busxact_seq`

## Requirements
- R1: After reset, rd_o, wr_o, burst_o, busgnt_o, done_o and berr_exc_o are low, while ad_oe_o and req_ready_o are high.
- R2: A request accepted while req_ready_o is high starts a transaction on the next cycle. Kind code 2'b11 (write) raises only wr_o. Kind codes 2'b00 (single read), 2'b01 (instruction refill) and 2'b10 (data refill) raise only rd_o. Both strobes are low whenever no transaction is running.
- R3: In the first transaction cycle ad_o carries the word address, zero-extended. On a write it carries the write data from the second cycle on.
- R4: Each rdcen_i in the data phase of a read stores ad_i into the next buffer slot. A single read completes once one rdcen_i and one ack_i have both been seen, in either order or together. done_o is then high for exactly one cycle, and rdata_o holds slot k in bits [k*32 +: 32]. Slots that were not filled read as zero, and rdata_o is zero whenever done_o is low.
- R5: An instruction refill (2'b01) holds burst_o high for the whole transaction and completes after four rdcen_i plus ack_i.
- R6: A data refill (2'b10) is a four-word burst if cfg_dburst_i was high in the last reset cycle. Otherwise it is a single-word read with burst_o low. The value of cfg_dburst_i after reset has no effect.
- R7: A write raises burst_o when the transaction before it was a write and both word addresses agree in bits 29..8. The first write after reset is not flagged.
- R8: A read, or a grant of the bus to an external master, placed between two writes stops the second write from being flagged.
- R9: A write completes on ack_i with a one-cycle done_o. A write to a different page raises no burst_o.
- R10: berr_i during a read data phase ends the transaction. berr_exc_o pulses for one cycle, done_o stays low, and any captured words are dropped.
- R11: berr_i during a write data phase ends the write with neither done_o nor berr_exc_o. berr_i, ack_i and rdcen_i have no effect while the bus is idle.
- R12: busreq_i is honoured only between transactions; a running transaction finishes first. While granted, busgnt_o is high, ad_oe_o, rd_o, wr_o and req_ready_o are low, and new requests are held off until busreq_i drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dburst_i | input | 1 | Data-refill burst option, sampled in the last reset cycle |
| req_valid_i | input | 1 | Core request valid |
| req_kind_i | input | 2 | 00 single read, 01 instruction refill, 10 data refill, 11 write |
| req_addr_i | input | 30 | Word address of the request |
| req_wdata_i | input | 32 | Write data |
| req_ready_o | output | 1 | Block can accept a request this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| berr_exc_o | output | 1 | One-cycle read bus-error exception pulse |
| rdata_o | output | 128 | Read buffer words, valid with done_o |
| ad_o | output | 32 | Multiplexed address/data bus, outgoing |
| ad_i | input | 32 | Multiplexed address/data bus, incoming |
| ad_oe_o | output | 1 | Bus output enable (ownership) |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| burst_o | output | 1 | Read burst / near write indication |
| ack_i | input | 1 | Memory acknowledge |
| rdcen_i | input | 1 | Read data valid, capture one word |
| berr_i | input | 1 | Bus error |
| busreq_i | input | 1 | External master bus request |
| busgnt_o | output | 1 | Bus granted to external master |

## Verification
The main function is exercised with a sequence of writes and reads. The addresses are chosen so that the near-write flag must go first-write clear, same-page set, page-change clear, and read-cleared, and the four request kinds are mixed into that stream. This separates a page compare that uses the wrong bit slice from one whose tracking state is never cleared. Single reads are run with acknowledge arriving before data and with both arriving together, so completion on either event alone shows up. Burst reads run with the data-refill option both off and on, with the option deasserted after reset. Bus errors are injected part way through a burst, on a write and on an idle bus, and bus requests are raised during a transaction and between two writes.

// File: rtl/busxact_pkg.sv
package busxact_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ADDR  = 2'b01,
        ST_DATA  = 2'b10,
        ST_GRANT = 2'b11
    } seq_state_e;

    typedef enum logic [1:0] {
        K_RD1  = 2'b00,
        K_IREF = 2'b01,
        K_DREF = 2'b10,
        K_WR   = 2'b11
    } req_kind_e;

endpackage

// File: rtl/busxact_near.sv
module busxact_near #(
    parameter int TW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] page_i,
    input  logic          wr_start_i,
    input  logic          clr_i,
    output logic          hit_o
);

    typedef struct packed {
        logic          valid;
        logic [TW-1:0] page;
    } near_t;

    near_t near_d, near_q;

    always_comb begin
        near_d = near_q;
        if (wr_start_i) begin
            near_d.valid = 1'b1;
            near_d.page  = page_i;
        end else if (clr_i) begin
            near_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) near_q <= '0;
        else        near_q <= near_d;
    end

    assign hit_o = near_q.valid && (near_q.page == page_i);

endmodule

// File: rtl/busxact_rdbuf.sv
module busxact_rdbuf #(
    parameter int DW = 32,
    parameter int BL = 4,
    parameter int IW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           cap_en_i,
    input  logic [IW-1:0]  cap_idx_i,
    input  logic [DW-1:0]  din_i,
    output logic [BL*DW-1:0] words_o
);

    logic [DW-1:0] slot_d [BL];
    logic [DW-1:0] slot_q [BL];

    for (genvar g = 0; g < BL; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (clr_i)
                slot_d[g] = '0;
            else if (cap_en_i && (cap_idx_i == IW'(g)))
                slot_d[g] = din_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d[g];
        end

        assign words_o[g*DW +: DW] = slot_q[g];
    end

endmodule

// File: rtl/busxact_ctrl.sv
module busxact_ctrl
    import busxact_pkg::*;
#(
    parameter int AW = 30,
    parameter int DW = 32,
    parameter int BL = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [1:0]    req_kind_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          req_ready_o,
    input  logic          dburst_mode_i,
    input  logic          near_hit_i,
    input  logic          ack_i,
    input  logic          rdcen_i,
    input  logic          berr_i,
    input  logic          busreq_i,
    output logic          rd_o,
    output logic          wr_o,
    output logic          burst_o,
    output logic          ad_oe_o,
    output logic          busgnt_o,
    output logic [DW-1:0] ad_o,
    output logic          wr_start_o,
    output logic          near_clr_o,
    output logic          cap_en_o,
    output logic [IW-1:0] cap_idx_o,
    output logic          buf_clr_o,
    output logic          done_o,
    output logic          berr_exc_o
);

    localparam int CW = $clog2(BL + 1);

    typedef struct packed {
        seq_state_e    st;
        logic          is_wr;
        logic          flag;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [CW-1:0] cnt;
        logic [CW-1:0] need;
        logic          ack_seen;
        logic          done;
        logic          berr_exc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [CW-1:0] cnt_nxt;
    logic          ack_nxt;
    logic          bursting;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.done     = 1'b0;
        ctl_d.berr_exc = 1'b0;
        wr_start_o     = 1'b0;
        near_clr_o     = 1'b0;
        cap_en_o       = 1'b0;
        buf_clr_o      = 1'b0;
        cnt_nxt        = ctl_q.cnt;
        ack_nxt        = ctl_q.ack_seen;
        bursting       = (req_kind_i == K_IREF) ||
                         ((req_kind_i == K_DREF) && dburst_mode_i);

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (busreq_i) begin
                    ctl_d.st   = ST_GRANT;
                    near_clr_o = 1'b1;
                end else if (req_valid_i) begin
                    ctl_d.st       = ST_ADDR;
                    ctl_d.addr     = req_addr_i;
                    ctl_d.wdata    = req_wdata_i;
                    ctl_d.cnt      = '0;
                    ctl_d.ack_seen = 1'b0;
                    if (req_kind_i == K_WR) begin
                        ctl_d.is_wr = 1'b1;
                        ctl_d.flag  = near_hit_i;
                        ctl_d.need  = CW'(1);
                        wr_start_o  = 1'b1;
                    end else begin
                        ctl_d.is_wr = 1'b0;
                        ctl_d.flag  = bursting;
                        ctl_d.need  = bursting ? CW'(BL) : CW'(1);
                        near_clr_o  = 1'b1;
                        buf_clr_o   = 1'b1;
                    end
                end
            end
            ST_ADDR: begin
                ctl_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (berr_i) begin
                    ctl_d.st       = ST_IDLE;
                    ctl_d.berr_exc = !ctl_q.is_wr;
                    buf_clr_o      = !ctl_q.is_wr;
                end else if (ctl_q.is_wr) begin
                    if (ack_i) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end else begin
                    if (rdcen_i && (ctl_q.cnt < ctl_q.need)) begin
                        cap_en_o = 1'b1;
                        cnt_nxt  = ctl_q.cnt + CW'(1);
                    end
                    ack_nxt        = ctl_q.ack_seen || ack_i;
                    ctl_d.cnt      = cnt_nxt;
                    ctl_d.ack_seen = ack_nxt;
                    if ((cnt_nxt == ctl_q.need) && ack_nxt) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end
            end
            ST_GRANT: begin
                near_clr_o = 1'b1;
                if (!busreq_i) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    logic active;
    logic [DW-1:0] addr_ext;

    always_comb begin
        active   = (ctl_q.st == ST_ADDR) || (ctl_q.st == ST_DATA);
        addr_ext = '0;
        addr_ext[AW-1:0] = ctl_q.addr;
        if (ctl_q.st == ST_ADDR)
            ad_o = addr_ext;
        else if ((ctl_q.st == ST_DATA) && ctl_q.is_wr)
            ad_o = ctl_q.wdata;
        else
            ad_o = '0;
    end

    assign rd_o        = active && !ctl_q.is_wr;
    assign wr_o        = active && ctl_q.is_wr;
    assign burst_o     = active && ctl_q.flag;
    assign ad_oe_o     = (ctl_q.st != ST_GRANT);
    assign busgnt_o    = (ctl_q.st == ST_GRANT);
    assign req_ready_o = (ctl_q.st == ST_IDLE) && !busreq_i;
    assign cap_idx_o   = ctl_q.cnt[IW-1:0];
    assign done_o      = ctl_q.done;
    assign berr_exc_o  = ctl_q.berr_exc;

endmodule

// File: rtl/busxact_seq.sv
module busxact_seq #(
    parameter int AW = 30,
    parameter int DW = 32,
    parameter int BL = 4,
    parameter int PB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dburst_i,
    input  logic             req_valid_i,
    input  logic [1:0]       req_kind_i,
    input  logic [AW-1:0]    req_addr_i,
    input  logic [DW-1:0]    req_wdata_i,
    output logic             req_ready_o,
    output logic             done_o,
    output logic             berr_exc_o,
    output logic [BL*DW-1:0] rdata_o,
    output logic [DW-1:0]    ad_o,
    input  logic [DW-1:0]    ad_i,
    output logic             ad_oe_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic             burst_o,
    input  logic             ack_i,
    input  logic             rdcen_i,
    input  logic             berr_i,
    input  logic             busreq_i,
    output logic             busgnt_o
);

    localparam int IW = $clog2(BL);
    localparam int TW = AW - PB;

    logic mode_d, mode_q;

    always_comb begin
        mode_d = rst_n ? mode_q : cfg_dburst_i;
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    logic          near_hit, wr_start, near_clr;
    logic          cap_en, buf_clr;
    logic [IW-1:0] cap_idx;
    logic [BL*DW-1:0] words;

    busxact_ctrl #(.AW(AW), .DW(DW), .BL(BL), .IW(IW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid_i),
        .req_kind_i    (req_kind_i),
        .req_addr_i    (req_addr_i),
        .req_wdata_i   (req_wdata_i),
        .req_ready_o   (req_ready_o),
        .dburst_mode_i (mode_q),
        .near_hit_i    (near_hit),
        .ack_i         (ack_i),
        .rdcen_i       (rdcen_i),
        .berr_i        (berr_i),
        .busreq_i      (busreq_i),
        .rd_o          (rd_o),
        .wr_o          (wr_o),
        .burst_o       (burst_o),
        .ad_oe_o       (ad_oe_o),
        .busgnt_o      (busgnt_o),
        .ad_o          (ad_o),
        .wr_start_o    (wr_start),
        .near_clr_o    (near_clr),
        .cap_en_o      (cap_en),
        .cap_idx_o     (cap_idx),
        .buf_clr_o     (buf_clr),
        .done_o        (done_o),
        .berr_exc_o    (berr_exc_o)
    );

    busxact_near #(.TW(TW)) u_near (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_i     (req_addr_i[AW-1:PB]),
        .wr_start_i (wr_start),
        .clr_i      (near_clr),
        .hit_o      (near_hit)
    );

    busxact_rdbuf #(.DW(DW), .BL(BL), .IW(IW)) u_rdbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .cap_en_i  (cap_en),
        .cap_idx_i (cap_idx),
        .din_i     (ad_i),
        .words_o   (words)
    );

    assign rdata_o = done_o ? words : '0;

endmodule

// File: rtl/busxact_chk.sv
module busxact_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_o,
    input logic wr_o,
    input logic burst_o,
    input logic busgnt_o,
    input logic ad_oe_o,
    input logic done_o,
    input logic berr_exc_o
);

    // R2
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o));

    // R12
    grant_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busgnt_o |-> (!rd_o && !wr_o && !ad_oe_o && !done_o));

    // R12
    grant_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busgnt_o) |-> $past(!rd_o && !wr_o));

    // R10
    exc_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        berr_exc_o |-> ($past(rd_o) && !done_o));

    // R4
    done_after_xact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rd_o || wr_o));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    burst_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_o || wr_o) && $past(rd_o || wr_o)) |-> $stable(burst_o));

    // R2
    burst_in_xact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_o |-> (rd_o || wr_o));

endmodule

bind busxact_seq busxact_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_o       (rd_o),
    .wr_o       (wr_o),
    .burst_o    (burst_o),
    .busgnt_o   (busgnt_o),
    .ad_oe_o    (ad_oe_o),
    .done_o     (done_o),
    .berr_exc_o (berr_exc_o)
);

// File: tb/busxact_seq_bench.sv
`timescale 1ns/1ps
module busxact_seq_bench;

    localparam int NV = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_dburst_i = 1'b0;
    logic         req_valid_i = 1'b0;
    logic [1:0]   req_kind_i = 2'b00;
    logic [29:0]  req_addr_i = '0;
    logic [31:0]  req_wdata_i = '0;
    logic         req_ready_o, done_o, berr_exc_o;
    logic [127:0] rdata_o;
    logic [31:0]  ad_o;
    logic [31:0]  ad_i = '0;
    logic         ad_oe_o, rd_o, wr_o, burst_o, busgnt_o;
    logic         ack_i = 1'b0, rdcen_i = 1'b0, berr_i = 1'b0, busreq_i = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    busxact_seq u_busxact_seq (
        .clk(clk), .rst_n(rst_n), .cfg_dburst_i(cfg_dburst_i),
        .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .req_ready_o(req_ready_o), .done_o(done_o), .berr_exc_o(berr_exc_o),
        .rdata_o(rdata_o), .ad_o(ad_o), .ad_i(ad_i), .ad_oe_o(ad_oe_o),
        .rd_o(rd_o), .wr_o(wr_o), .burst_o(burst_o), .ack_i(ack_i),
        .rdcen_i(rdcen_i), .berr_i(berr_i), .busreq_i(busreq_i),
        .busgnt_o(busgnt_o)
    );

    // fields: kind[35:34] addr[33:4] expected burst[3] words[2:0]
    localparam logic [35:0] VEC [NV] = '{
        {2'b11, 30'h0000_0100, 1'b0, 3'd0},
        {2'b11, 30'h0000_01A5, 1'b1, 3'd0},
        {2'b11, 30'h0000_02A5, 1'b0, 3'd0},
        {2'b11, 30'h0000_02FF, 1'b1, 3'd0},
        {2'b00, 30'h0000_02FF, 1'b0, 3'd1},
        {2'b11, 30'h0000_02F0, 1'b0, 3'd0},
        {2'b01, 30'h0000_0040, 1'b1, 3'd4},
        {2'b10, 30'h0000_0080, 1'b0, 3'd1},
        {2'b11, 30'h0000_3000, 1'b0, 3'd0},
        {2'b11, 30'h0000_30FF, 1'b1, 3'd0}
    };

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rword(input logic [29:0] a, input int i);
        return {a[15:0] ^ 16'h5A5A, 16'(i) + 16'h0C00};
    endfunction

    function automatic logic [31:0] wval(input logic [29:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    task automatic do_reset(input bit cfg_last);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_dburst_i = 1'b0;
        repeat (3) @(negedge clk);
        cfg_dburst_i = cfg_last;
        @(negedge clk);
        rst_n = 1'b1;
        cfg_dburst_i = 1'b0;
    endtask

    task automatic run_xact(input logic [1:0] k, input logic [29:0] a,
                            input int nw, input bit eb, input string tag);
        logic [127:0] exp_rd;
        @(negedge clk);
        req_valid_i = 1'b1;
        req_kind_i  = k;
        req_addr_i  = a;
        req_wdata_i = wval(a);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk("R2 rd strobe", 128'(rd_o), 128'(k != 2'b11));
        chk("R2 wr strobe", 128'(wr_o), 128'(k == 2'b11));
        chk("R3 address phase", 128'(ad_o), 128'({2'b00, a}));
        chk(tag, 128'(burst_o), 128'(eb));
        if (k == 2'b11) begin
            @(negedge clk);
            chk("R3 write data phase", 128'(ad_o), 128'(wval(a)));
            ack_i = 1'b1;
            @(negedge clk);
            ack_i = 1'b0;
            chk("R9 write done", 128'(done_o), 128'(1));
        end else begin
            for (int i = 0; i < nw; i++) begin
                @(negedge clk);
                chk(tag, 128'(burst_o), 128'(eb));
                rdcen_i = 1'b1;
                ad_i    = rword(a, i);
                ack_i   = (i == nw - 1);
            end
            @(negedge clk);
            rdcen_i = 1'b0;
            ack_i   = 1'b0;
            exp_rd  = '0;
            for (int s = 0; s < 4; s++)
                if (s < nw) exp_rd[s*32 +: 32] = rword(a, s);
            chk("R4 read done", 128'(done_o), 128'(1));
            chk("R4 read data", rdata_o, exp_rd);
        end
        @(negedge clk);
        chk("R4 done one cycle", 128'(done_o), 128'(0));
    endtask

    task automatic grant_cycle();
        @(negedge clk);
        busreq_i = 1'b1;
        @(negedge clk);
        chk("R12 granted", 128'(busgnt_o), 128'(1));
        chk("R12 bus released", 128'(ad_oe_o), 128'(0));
        busreq_i = 1'b0;
        @(negedge clk);
        chk("R12 grant dropped", 128'(busgnt_o), 128'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        @(negedge clk);
        // R1 reset state
        chk("R1 rd", 128'(rd_o), 128'(0));
        chk("R1 wr", 128'(wr_o), 128'(0));
        chk("R1 burst", 128'(burst_o), 128'(0));
        chk("R1 gnt", 128'(busgnt_o), 128'(0));
        chk("R1 done", 128'(done_o), 128'(0));
        chk("R1 exc", 128'(berr_exc_o), 128'(0));
        chk("R1 oe", 128'(ad_oe_o), 128'(1));
        chk("R1 ready", 128'(req_ready_o), 128'(1));

        // vector table: R7 near writes, R8 read clears, R5 burst, R6 mode off
        for (int v = 0; v < NV; v++) begin
            run_xact(VEC[v][35:34], VEC[v][33:4], int'(VEC[v][2:0]), VEC[v][3],
                     (VEC[v][35:34] == 2'b11) ? "R7 near flag" :
                     (VEC[v][35:34] == 2'b10) ? "R6 dref burst" : "R5 burst flag");
        end

        // R4 acknowledge before data
        @(negedge clk);
        req_valid_i = 1'b1; req_kind_i = 2'b00; req_addr_i = 30'h123;
        @(negedge clk);
        req_valid_i = 1'b0;
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk("R4 no done on ack alone", 128'(done_o), 128'(0));
        rdcen_i = 1'b1; ad_i = 32'hCAFE_0001;
        @(negedge clk);
        rdcen_i = 1'b0;
        chk("R4 ack-first done", 128'(done_o), 128'(1));
        chk("R4 ack-first data", rdata_o, 128'(32'hCAFE_0001));

        // R10 bus error mid burst
        @(negedge clk);
        req_valid_i = 1'b1; req_kind_i = 2'b01; req_addr_i = 30'h40;
        @(negedge clk);
        req_valid_i = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            rdcen_i = 1'b1; ad_i = rword(30'h40, i);
        end
        @(negedge clk);
        rdcen_i = 1'b0; berr_i = 1'b1;
        @(negedge clk);
        berr_i = 1'b0;
        chk("R10 exception", 128'(berr_exc_o), 128'(1));
        chk("R10 no done", 128'(done_o), 128'(0));
        chk("R10 read ended", 128'(rd_o), 128'(0));
        chk("R10 words dropped", rdata_o, 128'(0));
        @(negedge clk);
        chk("R10 exception pulse", 128'(berr_exc_o), 128'(0));

        // R11 bus error on write
        @(negedge clk);
        req_valid_i = 1'b1; req_kind_i = 2'b11; req_addr_i = 30'h600;
        @(negedge clk);
        req_valid_i = 1'b0;
        @(negedge clk);
        berr_i = 1'b1;
        @(negedge clk);
        berr_i = 1'b0;
        chk("R11 write ended", 128'(wr_o), 128'(0));
        chk("R11 write no done", 128'(done_o), 128'(0));
        chk("R11 write no exc", 128'(berr_exc_o), 128'(0));

        // R11 bus inputs ignored while idle
        @(negedge clk);
        berr_i = 1'b1; ack_i = 1'b1; rdcen_i = 1'b1;
        @(negedge clk);
        berr_i = 1'b0; ack_i = 1'b0; rdcen_i = 1'b0;
        chk("R11 idle berr", 128'(berr_exc_o), 128'(0));
        chk("R11 idle done", 128'(done_o), 128'(0));
        chk("R11 idle ready", 128'(req_ready_o), 128'(1));

        // R12 request during transaction
        @(negedge clk);
        req_valid_i = 1'b1; req_kind_i = 2'b00; req_addr_i = 30'h77;
        @(negedge clk);
        req_valid_i = 1'b0; busreq_i = 1'b1;
        chk("R12 xact kept", 128'(rd_o), 128'(1));
        chk("R12 no early grant", 128'(busgnt_o), 128'(0));
        @(negedge clk);
        rdcen_i = 1'b1; ack_i = 1'b1; ad_i = 32'h0000_0077;
        @(negedge clk);
        rdcen_i = 1'b0; ack_i = 1'b0;
        chk("R12 xact finished", 128'(done_o), 128'(1));
        chk("R12 grant after", 128'(busgnt_o), 128'(0));
        @(negedge clk);
        chk("R12 granted", 128'(busgnt_o), 128'(1));
        chk("R12 oe low", 128'(ad_oe_o), 128'(0));
        chk("R12 not ready", 128'(req_ready_o), 128'(0));
        req_valid_i = 1'b1; req_kind_i = 2'b00;
        @(negedge clk);
        chk("R12 request held off", 128'(rd_o), 128'(0));
        req_valid_i = 1'b0; busreq_i = 1'b0;
        @(negedge clk);
        chk("R12 released", 128'(busgnt_o), 128'(0));
        chk("R12 oe back", 128'(ad_oe_o), 128'(1));

        // R8 grant between two same-page writes
        run_xact(2'b11, 30'h500, 0, 1'b0, "R7 near flag first");
        grant_cycle();
        run_xact(2'b11, 30'h510, 0, 1'b0, "R8 grant clears near");

        // R6 data refill burst when option set in last reset cycle
        do_reset(1'b1);
        run_xact(2'b10, 30'h880, 4, 1'b1, "R6 dref burst on");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule